// File: doc/BRIEF.md
# Escaped Byte-Stream Packet Framer

This block turns a packet, offered one data byte per handshake with a flag on the final byte, into a continuous byte stream for a serial link. One output byte is produced on every clock. Between packets the stream carries the idle fill value 0x4A, which the far end discards. Each packet opens with a start marker, a channel marker and channel number zero. Any data byte that collides with a framing or link code is replaced by an escape character followed by the byte with bit 5 inverted. The end marker is placed in front of the final data byte, not after it.

The parameter `WORD_BYTES` selects word alignment. With a value above one, idle bytes are inserted ahead of the end marker so that the whole packet, counted from the start marker through the last emitted byte, fills a whole number of words. Input flow control is a valid/ready pair. The framer holds `in_ready` low in every cycle that emits a marker, an escape character or a pad byte. No data is ever dropped.

Top module: `pkt_byte_framer`

## Requirements
- R1: While reset is active and after it is released with no packet pending, `out_byte` is 0x4A and `in_ready` is low.
- R2: When `in_valid` is seen high in idle, the next three output bytes are 0x7A, 0x7C, 0x00, starting with the byte registered on that edge.
- R3: A data byte outside the set {0x4A, 0x4D, 0x7A, 0x7B, 0x7C, 0x7D} that is not the last byte is output unchanged in the cycle it is accepted.
- R4: A data byte of 0x7A, 0x7B, 0x7C or 0x7D is sent as 0x7D and then the byte XOR 0x20.
- R5: A data byte of 0x4A or 0x4D is sent as 0x4D and then the byte XOR 0x20.
- R6: The end marker 0x7B is output directly before the encoded last byte. A packet of a single byte is framed as 0x7A, 0x7C, 0x00, then any pad, 0x7B, then the byte.
- R7: When the last byte needs escaping, the order is 0x7B, the escape character, then the byte XOR 0x20.
- R8: When `in_valid` is low inside a packet, 0x4A is output for that cycle and no byte is lost.
- R9: With `WORD_BYTES` = 4, 0x4A pad bytes are inserted just before 0x7B so that the count of bytes from 0x7A through the final byte is a multiple of 4. Idle gaps inside the packet count toward this total.
- R10: With `WORD_BYTES` = 1, no pad bytes are inserted.
- R11: `in_ready` is high only while `in_valid` is high, and only in the cycle that emits the last output character of that byte. It is low during the three header cycles.
- R12: After the last byte is accepted, `in_ready` is low on the next cycle and the stream returns to 0x4A until the next packet.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A data byte is offered |
| in_data | input | 8 | Offered data byte |
| in_last | input | 1 | Offered byte is the final byte of the packet |
| in_ready | output | 1 | Offered byte is accepted on this edge |
| out_byte | output | 8 | Link byte, one per clock, registered |

## Verification
The assertions assume that a producer keeps `in_valid`, `in_data` and `in_last` steady from the moment it offers a byte until the byte is accepted. They also assume the producer does not withdraw a byte once the packet's start marker has been emitted. The bench driver raises `in_valid` only together with stable data and holds it until `in_ready` is sampled high. It places idle gaps only between accepted bytes, never in the middle of an offer. Both alignment variants are driven, so the padding rule is checked on the word-aligned instance and its absence on the byte-aligned one.

// File: rtl/pkt_framer_pkg.sv
package pkt_framer_pkg;

  localparam logic [7:0] CODE_SOP    = 8'h7A;
  localparam logic [7:0] CODE_EOP    = 8'h7B;
  localparam logic [7:0] CODE_CHAN   = 8'h7C;
  localparam logic [7:0] CODE_PKTESC = 8'h7D;
  localparam logic [7:0] CODE_IDLE   = 8'h4A;
  localparam logic [7:0] CODE_LNKESC = 8'h4D;
  localparam logic [7:0] CHAN_NUM    = 8'h00;
  localparam logic [7:0] FOLD_MASK   = 8'h20;

  typedef enum logic [2:0] {
    FR_IDLE,
    FR_CHMARK,
    FR_CHNUM,
    FR_DATA,
    FR_LAST,
    FR_ESCD
  } fr_state_t;

endpackage

// File: rtl/pkt_esc_classify.sv
module pkt_esc_classify
  import pkt_framer_pkg::*;
(
  input  logic [7:0] byte_in,
  output logic       needs_esc,
  output logic [7:0] esc_char,
  output logic [7:0] folded
);

  logic hit_pkt;
  logic hit_lnk;

  // R4: framing-layer codes take the packet escape
  assign hit_pkt = (byte_in == CODE_SOP) || (byte_in == CODE_EOP) ||
                   (byte_in == CODE_CHAN) || (byte_in == CODE_PKTESC);
  // R5: link-layer codes take the link escape
  assign hit_lnk = (byte_in == CODE_IDLE) || (byte_in == CODE_LNKESC);

  assign needs_esc = hit_pkt || hit_lnk;
  assign esc_char  = hit_pkt ? CODE_PKTESC : CODE_LNKESC;
  assign folded    = byte_in ^ FOLD_MASK;

endmodule

// File: rtl/pkt_word_align.sv
module pkt_word_align #(
  parameter int WORD_BYTES = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pos_clr,
  input  logic       pos_adv,
  input  logic [1:0] tail_len,
  output logic       aligned
);

  localparam int PW = (WORD_BYTES > 1) ? $clog2(WORD_BYTES) : 1;
  localparam logic [PW+1:0] MASK = (PW + 2)'(WORD_BYTES - 1);

  logic [PW-1:0] pos_q;
  logic [PW-1:0] pos_d;
  logic          pos_en;
  logic [PW+1:0] sum;

  // byte position inside the packet, modulo the word size
  always_comb begin
    pos_en = pos_clr || pos_adv;
    pos_d  = pos_clr ? PW'(1) : pos_q + PW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q <= '0;
    end else if (pos_en) begin
      pos_q <= pos_d;
    end
  end

  // R9 R10: the end marker may go out once the tail closes the word
  assign sum     = (PW + 2)'(pos_q) + (PW + 2)'(tail_len);
  assign aligned = ((sum & MASK) == '0);

endmodule

// File: rtl/pkt_byte_framer.sv
module pkt_byte_framer
  import pkt_framer_pkg::*;
#(
  parameter int WORD_BYTES = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  input  logic [7:0] in_data,
  input  logic       in_last,
  output logic       in_ready,
  output logic [7:0] out_byte
);

  fr_state_t  state_q;
  fr_state_t  state_d;
  logic [7:0] out_q;
  logic [7:0] out_d;
  logic       needs_esc;
  logic [7:0] esc_char;
  logic [7:0] folded;
  logic       pos_clr;
  logic       pos_adv;
  logic       aligned;
  logic [1:0] tail_len;

  pkt_esc_classify u_cls (
    .byte_in   (in_data),
    .needs_esc (needs_esc),
    .esc_char  (esc_char),
    .folded    (folded)
  );

  assign tail_len = needs_esc ? 2'd3 : 2'd2;
  assign pos_adv  = (state_q != FR_IDLE);

  pkt_word_align #(.WORD_BYTES(WORD_BYTES)) u_align (
    .clk      (clk),
    .rst_n    (rst_n),
    .pos_clr  (pos_clr),
    .pos_adv  (pos_adv),
    .tail_len (tail_len),
    .aligned  (aligned)
  );

  always_comb begin
    state_d  = state_q;
    out_d    = CODE_IDLE;
    in_ready = 1'b0;
    pos_clr  = 1'b0;
    unique case (state_q)
      FR_IDLE: begin
        if (in_valid) begin
          out_d   = CODE_SOP;            // R2
          pos_clr = 1'b1;
          state_d = FR_CHMARK;
        end
      end
      FR_CHMARK: begin
        out_d   = CODE_CHAN;
        state_d = FR_CHNUM;
      end
      FR_CHNUM: begin
        out_d   = CHAN_NUM;
        state_d = FR_DATA;
      end
      FR_DATA: begin
        if (in_valid) begin
          if (in_last) begin
            if (aligned) begin
              out_d   = CODE_EOP;        // R6
              state_d = FR_LAST;
            end
          end else if (needs_esc) begin
            out_d   = esc_char;
            state_d = FR_ESCD;
          end else begin
            out_d    = in_data;          // R3
            in_ready = 1'b1;
          end
        end
      end
      FR_LAST: begin
        if (needs_esc) begin
          out_d   = esc_char;            // R7
          state_d = FR_ESCD;
        end else begin
          out_d    = in_data;
          in_ready = 1'b1;
          state_d  = FR_IDLE;            // R12
        end
      end
      FR_ESCD: begin
        out_d    = folded;
        in_ready = 1'b1;
        state_d  = in_last ? FR_IDLE : FR_DATA;
      end
      default: state_d = FR_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= FR_IDLE;
      out_q   <= CODE_IDLE;
    end else begin
      state_q <= state_d;
      out_q   <= out_d;
    end
  end

  assign out_byte = out_q;

endmodule

// File: rtl/pkt_byte_framer_chk.sv
module pkt_byte_framer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic [7:0] in_data,
  input logic       in_last,
  input logic       in_ready,
  input logic [7:0] out_byte
);

  a_r2_chan_marker: assert property (@(posedge clk) disable iff (!rst_n)
    (out_byte == 8'h7A) |=> (out_byte == 8'h7C));

  a_r2_chan_number: assert property (@(posedge clk) disable iff (!rst_n)
    (out_byte == 8'h7C) |=> (out_byte == 8'h00));

  a_r4_pkt_escape: assert property (@(posedge clk) disable iff (!rst_n)
    (out_byte == 8'h7D) |=> (out_byte == 8'h5A || out_byte == 8'h5B ||
                             out_byte == 8'h5C || out_byte == 8'h5D));

  a_r5_link_escape: assert property (@(posedge clk) disable iff (!rst_n)
    (out_byte == 8'h4D) |=> (out_byte == 8'h6A || out_byte == 8'h6D));

  a_r6_eop_then_data: assert property (@(posedge clk) disable iff (!rst_n)
    (out_byte == 8'h7B) |=> !(out_byte == 8'h7A || out_byte == 8'h7B ||
                              out_byte == 8'h7C || out_byte == 8'h4A));

  a_r11_ready_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> in_valid);

  a_r12_idle_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_last) |=> !in_ready);

  // producer rule relied on by R8: an offer is held until taken
  a_r8_offer_held: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_ready) |=> (in_valid && $stable(in_data) && $stable(in_last)));

endmodule

bind pkt_byte_framer pkt_byte_framer_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .in_data  (in_data),
  .in_last  (in_last),
  .in_ready (in_ready),
  .out_byte (out_byte)
);

// File: tb/test_pkt_byte_framer.sv
module test_pkt_byte_framer;

  logic            clk;
  logic            rst_n;
  logic [1:0]      vld;
  logic [1:0]      lst;
  logic [1:0][7:0] dat;
  logic [1:0]      rdy;
  logic [7:0]      obyte0;
  logic [7:0]      obyte1;

  int    n_chk;
  int    n_fail;
  bit    mon_en;
  string cur_req;
  logic [7:0] q0[$];
  logic [7:0] q1[$];

  pkt_byte_framer #(.WORD_BYTES(4)) i_pkt_byte_framer (
    .clk(clk), .rst_n(rst_n), .in_valid(vld[0]), .in_data(dat[0]),
    .in_last(lst[0]), .in_ready(rdy[0]), .out_byte(obyte0));

  pkt_byte_framer #(.WORD_BYTES(1)) i_pkt_byte_framer_nopad (
    .clk(clk), .rst_n(rst_n), .in_valid(vld[1]), .in_data(dat[1]),
    .in_last(lst[1]), .in_ready(rdy[1]), .out_byte(obyte1));

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h t=%0t", req, act, exp, $time);
    end
  endtask

  // reference: each clock, the next expected link byte, or idle fill
  always @(negedge clk) begin
    if (mon_en) begin
      check({cur_req, " pad4"}, obyte0, (q0.size() != 0) ? q0.pop_front() : 8'h4A);
      check({cur_req, " pad1"}, obyte1, (q1.size() != 0) ? q1.pop_front() : 8'h4A);
    end
  end

  function automatic bit is_res(logic [7:0] b);
    return (b == 8'h7A) || (b == 8'h7B) || (b == 8'h7C) || (b == 8'h7D) ||
           (b == 8'h4A) || (b == 8'h4D);
  endfunction

  function automatic void put_enc(ref logic [7:0] s[$], input logic [7:0] b);
    if (b >= 8'h7A && b <= 8'h7D) begin s.push_back(8'h7D); s.push_back(b ^ 8'h20); end
    else if (b == 8'h4A || b == 8'h4D) begin s.push_back(8'h4D); s.push_back(b ^ 8'h20); end
    else s.push_back(b);
  endfunction

  task automatic send(int sel, logic [7:0] d[$], int g[$]);
    logic [7:0] s[$];
    int w;
    bit hs;
    bit first;
    w = (sel == 0) ? 4 : 1;
    s = {8'h7A, 8'h7C, 8'h00};
    for (int i = 0; i < d.size(); i++) begin
      if (i > 0) for (int k = 0; k < g[i]; k++) s.push_back(8'h4A);
      if (i < d.size() - 1) put_enc(s, d[i]);
      else begin
        int tail;
        tail = is_res(d[i]) ? 3 : 2;
        while (((s.size() + tail) % w) != 0) s.push_back(8'h4A);
        s.push_back(8'h7B);
        put_enc(s, d[i]);
      end
    end
    for (int i = 0; i < d.size(); i++) begin
      if (i > 0) begin
        vld[sel] = 1'b0;
        for (int k = 0; k < g[i]; k++) begin @(posedge clk); #2; end
      end
      vld[sel] = 1'b1;
      dat[sel] = d[i];
      lst[sel] = (i == d.size() - 1);
      first = (i == 0);
      do begin
        @(negedge clk); #1;
        if (first) begin
          check("R11 ready low at start marker", {7'd0, rdy[sel]}, 8'd0);
          foreach (s[j]) if (sel == 0) q0.push_back(s[j]); else q1.push_back(s[j]);
          first = 1'b0;
        end
        hs = rdy[sel];
        @(posedge clk); #2;
      end while (!hs);
    end
    vld[sel] = 1'b0;
    lst[sel] = 1'b0;
    while ((sel == 0 ? q0.size() : q1.size()) != 0) begin @(posedge clk); #2; end
    cur_req = "R12 idle after packet";
    repeat (3) begin @(posedge clk); #2; end
  endtask

  initial begin
    n_chk = 0; n_fail = 0; mon_en = 1'b0; cur_req = "R1";
    vld = '0; lst = '0; dat = '0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset out pad4", obyte0, 8'h4A);
    check("R1 reset out pad1", obyte1, 8'h4A);
    check("R1 reset ready", {6'd0, rdy}, 8'd0);
    @(posedge clk); #2;
    rst_n = 1'b1;
    mon_en = 1'b1;
    repeat (3) begin @(posedge clk); #2; end

    cur_req = "R2 R3 plain";
    send(0, {8'h11, 8'h22, 8'h33, 8'h44}, {0, 0, 0, 0});
    cur_req = "R4 packet escape";
    send(0, {8'h7A, 8'h7B, 8'h7C, 8'h7D, 8'h55}, {0, 0, 0, 0, 0});
    cur_req = "R5 link escape";
    send(0, {8'h4A, 8'h4D, 8'h01}, {0, 0, 0});
    cur_req = "R6 single byte";
    send(0, {8'h99}, {0});
    cur_req = "R7 escaped last";
    send(0, {8'h10, 8'h7D}, {0, 0});
    send(1, {8'h10, 8'h4A}, {0, 0});
    cur_req = "R8 gaps";
    send(0, {8'h01, 8'h02, 8'h7C, 8'h03}, {0, 3, 2, 1});
    send(1, {8'h05, 8'h4D, 8'h06}, {0, 2, 4});
    for (int len = 1; len <= 9; len++) begin
      logic [7:0] d[$];
      int g[$];
      for (int i = 0; i < len; i++) begin
        d.push_back(((i % 3) == 2) ? 8'h7A + 8'(i % 4) : 8'((i * 37 + len * 11) & 8'hFF));
        g.push_back((i % 4) == 1 ? 1 : 0);
      end
      cur_req = "R9 word pad";
      send(0, d, g);
      cur_req = "R10 no pad";
      send(1, d, g);
    end
    mon_en = 1'b0;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule